// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Slave Port

This block connects the shared address/data bus of an 8-bit microcontroller to an internal byte-wide RAM. A configuration input chooses between two bus arrangements. In non-page mode the data byte shares the bus pins with address bits [7:0], and the dedicated address pins carry bits [15:8]. In page mode the data byte shares the bus pins with address bits [15:8], and the dedicated pins carry bits [7:0]. One extra pin supplies address bit 16, so the address is 17 bits wide.

A fast system clock samples every bus pin. An ALE pulse latches the byte that is on the bus at that moment. In page mode the microcontroller can run "page hit" cycles that have no ALE pulse. In those cycles the block reuses the upper byte it latched last and takes the low byte from the dedicated pins. A falling edge of a selected strobe starts an access and captures the full address. During a read, the stored byte is driven onto the bus. A write commits the bus byte when the write strobe rises.

The RAM occupies a window chosen by a parameter. Accesses outside that window are ignored.

Top module: `mbus_slave`

## Requirements
- R1: After reset, `busOe` is 0 and stays 0 until a read strobe is applied.
- R2: In non-page mode (`pageMode`=0), the falling edge of `ale` latches `busIn` as address bits [7:0]. `addrPins` supply bits [15:8] and `addrHi` supplies bit 16.
- R3: In page mode (`pageMode`=1), the falling edge of `ale` latches `busIn` as address bits [15:8]. `addrPins` supply bits [7:0] and `addrHi` supplies bit 16.
- R4: A page-hit access is a page-mode access with no `ale` pulse. It uses the last latched upper byte together with the `addrPins` value present when the access starts.
- R5: `busOe` is 1 only while a selected read strobe is low and the captured address is inside the window. `busOe` falls within two clock cycles of the strobe's release.
- R6: An address is in the window when bits [16:10] equal 7'h40, which covers 0x10000 to 0x103FF. Outside the window, reads leave `busOe` at 0 and writes change no stored byte.
- R7: A write (`wrN` low then high) stores the `busIn` byte present at the rising edge of `wrN` at the captured address. A later read of that address returns the byte.
- R8: With `readSingle`=0, either `ctl1N` or `ctl2N` low performs a read. With `readSingle`=1, only `ctl1N` reads, and `ctl2N` has no effect on the bus.
- R9: Address bit 0 selects the even byte (0) or the odd byte (1), and each is stored on its own. `bheN` has no effect.
- R10: The address is captured on the falling edge of the synchronized strobe. Changes on the address pins during the strobe do not alter the byte being read.
- R11: The latched byte changes only after a falling edge of `ale`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pageMode | input | 1 | 1 selects page mode, 0 selects non-page mode |
| readSingle | input | 1 | 1 accepts `ctl1N` as the only read strobe |
| ale | input | 1 | Address latch enable, active high |
| ctl1N | input | 1 | First read strobe, active low |
| ctl2N | input | 1 | Second read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| bheN | input | 1 | Byte-high enable (has no effect) |
| addrHi | input | 1 | Address bit 16 |
| addrPins | input | 8 | Dedicated address pins: bits [15:8] in non-page mode, bits [7:0] in page mode |
| busIn | input | 8 | Shared address/data bus, input side |
| busOut | output | 8 | Read data for the shared bus |
| busOe | output | 1 | Output enable for the shared bus |

## Verification
The assertions are evaluated on every cycle. They check that:
- the latched byte changes only after an ALE falling edge;
- the captured address changes only after an access starts;
- the output enable follows a synchronized read strobe and drops soon after the strobe is released.

Only the bench scenarios can show the following:
- that the two address arrangements assemble the same 17-bit location;
- that a page hit reuses the stored upper byte;
- that out-of-window writes and a masked second strobe leave the bus and the memory unchanged;
- that every read returns the byte the reference array predicts.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef struct packed {
    logic latchAddr;    // synchronized ALE has fallen
    logic startAccess;  // selected strobe has fallen
    logic commitWrite;  // write strobe has risen
    logic driveRead;    // read in progress, data registered
  } ctlStrobes_t;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[0] <= RST_VAL;
        else       stg[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) stg[s] <= RST_VAL;
        else       stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        readSingle,
  input  logic        aleS,
  input  logic        ctl1S,
  input  logic        ctl2S,
  input  logic        wrS,
  output logic        rdLowS,
  output ctlStrobes_t strb
);
  logic aleQ, rdLowQ, wrQ, readActive, readOn;

  // a read strobe counts only if it is selected
  assign rdLowS = !ctl1S || (!readSingle && !ctl2S);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aleQ       <= 1'b0;
      rdLowQ     <= 1'b0;
      wrQ        <= 1'b1;
      readActive <= 1'b0;
      readOn     <= 1'b0;
    end else begin
      aleQ       <= aleS;
      rdLowQ     <= rdLowS;
      wrQ        <= wrS;
      readActive <= rdLowS && (readActive || !rdLowQ);
      readOn     <= readActive && rdLowS;
    end
  end

  always_comb begin
    strb.latchAddr   = !aleS && aleQ;
    strb.startAccess = (rdLowS && !rdLowQ) || (!wrS && wrQ);
    strb.commitWrite = wrS && !wrQ;
    strb.driveRead   = readOn;
  end
endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned MEM_AW  = 10,
  parameter int unsigned WIN_TAG = 'h40,
  localparam int unsigned ADDR_W = 2 * BYTE_W + 1,
  localparam int unsigned TAG_W  = ADDR_W - MEM_AW,
  localparam int unsigned DEPTH  = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic              pageMode,
  input  logic              addrHi,
  input  logic [BYTE_W-1:0] addrPins,
  input  logic [BYTE_W-1:0] busIn,
  output logic [BYTE_W-1:0] latchByte,
  output logic [ADDR_W-1:0] accessAddr,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [BYTE_W-1:0] rdData;
  logic [MEM_AW-1:0] memIdx;
  logic              inWin;

  // the latched byte is the low half in non-page mode and the high half in page mode
  always_comb begin
    if (pageMode) curAddr = {addrHi, latchByte, addrPins};
    else          curAddr = {addrHi, addrPins, latchByte};
  end

  assign memIdx = accessAddr[MEM_AW-1:0];
  assign inWin  = accessAddr[ADDR_W-1:MEM_AW] == TAG_W'(WIN_TAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchByte  <= '0;
      accessAddr <= '0;
      rdData     <= '0;
    end else begin
      if (strb.latchAddr)   latchByte  <= busIn;
      if (strb.startAccess) accessAddr <= curAddr;
      rdData <= mem[memIdx];
    end
  end

  always_ff @(posedge clk)
    if (strb.commitWrite && inWin) mem[memIdx] <= busIn;

  assign busOut = rdData;
  assign busOe  = strb.driveRead && inWin;
endmodule

// File: rtl/mbus_slave.sv
module mbus_slave
  import mbus_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned MEM_AW      = 10,
  parameter int unsigned WIN_TAG     = 'h40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageMode,
  input  logic              readSingle,
  input  logic              ale,
  input  logic              ctl1N,
  input  logic              ctl2N,
  input  logic              wrN,
  input  logic              bheN,
  input  logic              addrHi,
  input  logic [BYTE_W-1:0] addrPins,
  input  logic [BYTE_W-1:0] busIn,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe
);
  localparam int unsigned ADDR_W = 2 * BYTE_W + 1;

  logic [3:0]        syncIn, syncOut;
  logic              rdLowS;
  ctlStrobes_t       strb;
  logic [BYTE_W-1:0] latchByte;
  logic [ADDR_W-1:0] accessAddr;
  logic              unusedBhe;

  // byte lanes are chosen by address bit 0 only
  assign unusedBhe = bheN;
  assign syncIn    = {wrN, ctl2N, ctl1N, ale};

  mbus_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
    .clk(clk), .rstN(rstN), .din(syncIn), .dout(syncOut)
  );

  mbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .readSingle(readSingle),
    .aleS(syncOut[0]), .ctl1S(syncOut[1]), .ctl2S(syncOut[2]), .wrS(syncOut[3]),
    .rdLowS(rdLowS), .strb(strb)
  );

  mbus_datapath #(.BYTE_W(BYTE_W), .MEM_AW(MEM_AW), .WIN_TAG(WIN_TAG)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pageMode(pageMode),
    .addrHi(addrHi), .addrPins(addrPins), .busIn(busIn),
    .latchByte(latchByte), .accessAddr(accessAddr),
    .busOut(busOut), .busOe(busOe)
  );
endmodule

// File: rtl/mbus_slave_chk.sv
module mbus_slave_chk #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              busOe,
  input logic              rdLowS,
  input logic              latchAddr,
  input logic              startAccess,
  input logic [BYTE_W-1:0] latchByte,
  input logic [ADDR_W-1:0] accessAddr
);
  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(latchByte) |-> $past(latchAddr));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(accessAddr) |-> $past(startAccess));

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdLowS |=> !busOe);

  // R5
  oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> $past(rdLowS));
endmodule

bind mbus_slave mbus_slave_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busOe(busOe), .rdLowS(rdLowS),
  .latchAddr(strb.latchAddr), .startAccess(strb.startAccess),
  .latchByte(latchByte), .accessAddr(accessAddr)
);

// File: tb/mbus_slave_bench.sv
module mbus_slave_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pageMode = 1'b0, readSingle = 1'b0, ale = 1'b0;
  logic ctl1N = 1'b1, ctl2N = 1'b1, wrN = 1'b1, bheN = 1'b1, addrHi = 1'b0;
  logic [7:0] addrPins = '0, busIn = '0;
  logic [7:0] busOut;
  logic busOe;

  logic [7:0] refMem [1024];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbus_slave u_mbus_slave (
    .clk(clk), .rstN(rstN), .pageMode(pageMode), .readSingle(readSingle),
    .ale(ale), .ctl1N(ctl1N), .ctl2N(ctl2N), .wrN(wrN), .bheN(bheN),
    .addrHi(addrHi), .addrPins(addrPins), .busIn(busIn),
    .busOut(busOut), .busOe(busOe)
  );

  function automatic bit inWin(logic [16:0] a);
    return a[16:10] == 7'h40;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic addrNonPage(logic [16:0] a);
    addrHi = a[16]; addrPins = a[15:8]; busIn = a[7:0];
    ale = 1'b1; waitc(3); ale = 1'b0; waitc(4);
  endtask

  task automatic addrPageMiss(logic [16:0] a);
    addrHi = a[16]; addrPins = a[7:0]; busIn = a[15:8];
    ale = 1'b1; waitc(3); ale = 1'b0; waitc(4);
  endtask

  task automatic addrPageHit(logic [16:0] a);
    addrHi = a[16]; addrPins = a[7:0]; waitc(2);
  endtask

  task automatic writeByte(logic [16:0] a, logic [7:0] d);
    busIn = d; bheN = ~bheN; waitc(1);
    wrN = 1'b0; waitc(5);
    wrN = 1'b1; waitc(6);
    if (inWin(a)) refMem[a[9:0]] = d;
  endtask

  task automatic readByte(string req, logic [16:0] a, bit useCtl2, bit expOe);
    if (useCtl2) ctl2N = 1'b0; else ctl1N = 1'b0;
    waitc(8);
    check({req, " oe"}, busOe, expOe);
    if (expOe) check({req, " data"}, busOut, refMem[a[9:0]]);
    ctl1N = 1'b1; ctl2N = 1'b1;
    waitc(6);
    check({req, " oe released"}, busOe, 1'b0);
  endtask

  task automatic testReset();
    check("R1 reset oe", busOe, 1'b0);
    waitc(10);
    check("R1 idle oe", busOe, 1'b0);
  endtask

  task automatic testNonPage();
    pageMode = 1'b0;
    addrNonPage(17'h10006); writeByte(17'h10006, 8'hA6);
    addrNonPage(17'h10007); writeByte(17'h10007, 8'h37);
    addrNonPage(17'h10206); writeByte(17'h10206, 8'hC2);
    addrNonPage(17'h10006); readByte("R2 R9 even byte", 17'h10006, 0, 1);
    addrNonPage(17'h10007); readByte("R9 odd byte bheN toggled", 17'h10007, 0, 1);
    addrNonPage(17'h10206); readByte("R2 R7 upper pins", 17'h10206, 1, 1);
  endtask

  task automatic testPage();
    pageMode = 1'b1;
    addrPageMiss(17'h10123); writeByte(17'h10123, 8'h5A);
    addrPageHit(17'h10124);  writeByte(17'h10124, 8'h24);
    addrPageHit(17'h10125);  writeByte(17'h10125, 8'h25);
    addrPageHit(17'h10180);  writeByte(17'h10180, 8'h80);
    addrPageMiss(17'h10123); readByte("R3 page miss read", 17'h10123, 0, 1);
    addrPageHit(17'h10124);  readByte("R4 page hit read", 17'h10124, 0, 1);
    addrPageHit(17'h10125);  readByte("R4 page hit odd", 17'h10125, 1, 1);
    // same location assembled the other way
    pageMode = 1'b0;
    addrNonPage(17'h10180); readByte("R4 R2 hit write seen in non-page", 17'h10180, 0, 1);
    addrNonPage(17'h10006); readByte("R3 R2 earlier byte intact", 17'h10006, 0, 1);
  endtask

  task automatic testWindow();
    pageMode = 1'b0;
    addrNonPage(17'h00123); writeByte(17'h00123, 8'hFF);
    readByte("R6 out of window read", 17'h00123, 0, 0);
    addrNonPage(17'h14123); writeByte(17'h14123, 8'hEE);
    readByte("R6 tag mismatch read", 17'h14123, 0, 0);
    addrNonPage(17'h10123); readByte("R6 window byte unchanged", 17'h10123, 0, 1);
  endtask

  task automatic testStrobeSel();
    pageMode = 1'b0;
    addrNonPage(17'h10007);
    readSingle = 1'b1;
    readByte("R8 ctl2N masked", 17'h10007, 1, 0);
    readByte("R8 ctl1N single read", 17'h10007, 0, 1);
    readSingle = 1'b0;
    readByte("R8 ctl2N dual read", 17'h10007, 1, 1);
  endtask

  task automatic testCapture();
    pageMode = 1'b1;
    addrPageMiss(17'h10124);
    ctl1N = 1'b0; waitc(8);
    check("R10 before pin change", busOut, refMem[10'h124]);
    addrPins = 8'h25; waitc(6);
    check("R10 oe held", busOe, 1'b1);
    check("R10 data held", busOut, refMem[10'h124]);
    ctl1N = 1'b1; waitc(6);
    readByte("R10 next access takes new pins", 17'h10125, 0, 1);
    addrPins = 8'h80; busIn = 8'h03; waitc(8);
    readByte("R11 no ale keeps upper byte", 17'h10180, 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) refMem[i] = 8'h00;
    waitc(3);
    testReset();
    rstN = 1'b1;
    waitc(4);
    testReset();
    testNonPage();
    testPage();
    testWindow();
    testStrobeSel();
    testCapture();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule